// File: doc/BRIEF.md
# Strobed Input Port with Handshake and Interrupt

This block is a single byte-wide input port that a peripheral fills with a strobe handshake. While the peripheral holds its active-low strobe low, the port captures the byte on its pins and raises a buffer-full flag back to the peripheral. Once the strobe has returned high, the buffer holds data and the interrupt enable is set, the block raises an interrupt request toward the CPU.

The CPU empties the port with an active-low read strobe. The interrupt drops on the falling edge of that strobe, which is when the read starts. The buffer-full flag drops on its rising edge, which is when the read ends. Strobe and read may arrive from outside the clock domain, so both pass through a flop synchronizer. The port pins go through a matching synchronizer, so the captured byte lines up with the strobe.

The interrupt enable flip-flop is written with a single-bit set/reset command. The command carries a bit index and a value, and only one index selects this port's enable. A mode-select pulse clears the enable. Bus address decoding is not part of the block.

Top module: `strobe_in_port`

## Requirements
- R1: After reset, data_o is 0, and ibf_o, intr_o and inte_o are all 0.
- R2: While the synchronized strobe is low, the synchronized pins are copied into data_o. data_o shows a byte no more than 3 clock edges after stb_ni goes low, and it does not change while the strobe is high.
- R3: ibf_o goes to 1 at the third clock edge after stb_ni goes low.
- R4: ibf_o stays 1 while rd_ni is low and goes to 0 only after rd_ni rises again. A read leaves data_o unchanged.
- R5: intr_o goes to 1 when the synchronized strobe is high, ibf_o is 1, inte_o is 1 and no read is in progress.
- R6: intr_o goes to 0 after the falling edge of rd_ni and stays 0 for the whole read.
- R7: A set/reset command (bsr_we_i=1) with bsr_sel_i equal to 4 loads bsr_val_i into inte_o. This is the default side A; side B uses bit 2. A command with any other bsr_sel_i value leaves inte_o unchanged.
- R8: A mode_sel_i pulse clears inte_o, even if a set/reset command arrives in the same cycle.
- R9: If the peripheral strobes again while ibf_o is already 1, the new byte overwrites the old one, and data_o holds only the most recent byte.
- R10: While inte_o is 0, intr_o is 0 from the next clock edge on, whatever the buffer state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | DATA_W | Peripheral data pins |
| stb_ni | input | 1 | Peripheral strobe, active low, asynchronous |
| rd_ni | input | 1 | CPU read strobe for this port, active low, asynchronous |
| bsr_we_i | input | 1 | Single-bit set/reset command valid |
| bsr_sel_i | input | 3 | Bit index of the set/reset command |
| bsr_val_i | input | 1 | Value written by the set/reset command |
| mode_sel_i | input | 1 | Mode-selection pulse; clears the interrupt enable |
| data_o | output | DATA_W | Latched port byte |
| ibf_o | output | 1 | Input buffer full flag |
| intr_o | output | 1 | Interrupt request to the CPU |
| inte_o | output | 1 | Interrupt enable flip-flop |

## Verification
The bench uses the defaults: an 8-bit port, a two-stage synchronizer and side A, so the enable sits at set/reset bit 4. With these values, random set/reset commands reach all eight bit indices, and each of the seven that must be ignored is observed at inte_o and intr_o. Strobe widths of one to three cycles are covered, including one-cycle pulses at the edge of what the synchronizer can catch. Back-to-back strobes with no read between them exercise the overwrite path.

// File: rtl/sip_pkg.sv
package sip_pkg;
  typedef enum logic {SIDE_A = 1'b0, SIDE_B = 1'b1} side_e;
  localparam int BSR_SEL_W = 3;
  localparam int INTE_POS_A = 4;
  localparam int INTE_POS_B = 2;
endpackage

// File: rtl/sip_sync.sv
module sip_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] q;

  if (STAGES == 1) begin : g_one
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q[0] <= RST_VAL;
      else         q[0] <= d_i;
    end
  end else begin : g_chain
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= {STAGES{RST_VAL}};
      else         q <= {q[STAGES-2:0], d_i};
    end
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/sip_inte.sv
module sip_inte
  import sip_pkg::*;
#(
  parameter side_e SIDE = SIDE_A
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bsr_we_i,
  input  logic [BSR_SEL_W-1:0] bsr_sel_i,
  input  logic                 bsr_val_i,
  input  logic                 mode_sel_i,
  output logic                 inte_o
);
  logic hit;

  if (SIDE == SIDE_A) begin : g_side_a
    assign hit = bsr_we_i && (bsr_sel_i == BSR_SEL_W'(INTE_POS_A));
  end else begin : g_side_b
    assign hit = bsr_we_i && (bsr_sel_i == BSR_SEL_W'(INTE_POS_B));
  end

  // mode selection wins over a same-cycle set/reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         inte_o <= 1'b0;
    else if (mode_sel_i) inte_o <= 1'b0;
    else if (hit)        inte_o <= bsr_val_i;
  end
endmodule

// File: rtl/sip_hs.sv
module sip_hs #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_s_i,
  input  logic              rd_s_i,
  input  logic [DATA_W-1:0] pins_s_i,
  input  logic              inte_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ibf_o,
  output logic              intr_o,
  output logic              rd_prev_o
);
  logic rd_rise, rd_fall, intr_set;

  assign rd_rise  = rd_s_i & ~rd_prev_o;
  assign rd_fall  = ~rd_s_i & rd_prev_o;
  // no set while a read is running or on the cycle it ends
  assign intr_set = stb_s_i & ibf_o & rd_s_i & rd_prev_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o    <= '0;
      ibf_o     <= 1'b0;
      intr_o    <= 1'b0;
      rd_prev_o <= 1'b1;
    end else begin
      rd_prev_o <= rd_s_i;
      if (!stb_s_i) data_o <= pins_s_i;
      // a new strobe beats a read ending in the same cycle
      if (!stb_s_i)     ibf_o <= 1'b1;
      else if (rd_rise) ibf_o <= 1'b0;
      if (rd_fall || !inte_i) intr_o <= 1'b0;
      else if (intr_set)      intr_o <= 1'b1;
    end
  end
endmodule

// File: rtl/strobe_in_port.sv
module strobe_in_port
  import sip_pkg::*;
#(
  parameter int    DATA_W      = 8,
  parameter int    SYNC_STAGES = 2,
  parameter side_e SIDE        = SIDE_A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] pins_i,
  input  logic              stb_ni,
  input  logic              rd_ni,
  input  logic              bsr_we_i,
  input  logic [2:0]        bsr_sel_i,
  input  logic              bsr_val_i,
  input  logic              mode_sel_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ibf_o,
  output logic              intr_o,
  output logic              inte_o
);
  logic [1:0]        ctl_s;
  logic              stb_s, rd_s, rd_prev;
  logic [DATA_W-1:0] pins_s;

  sip_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) i_ctl_sync (
    .clk_i, .rst_ni, .d_i({stb_ni, rd_ni}), .q_o(ctl_s)
  );
  assign stb_s = ctl_s[1];
  assign rd_s  = ctl_s[0];

  // pins delayed alongside the strobe so the byte lines up
  sip_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) i_pin_sync (
    .clk_i, .rst_ni, .d_i(pins_i), .q_o(pins_s)
  );

  sip_inte #(.SIDE(SIDE)) i_inte (
    .clk_i, .rst_ni, .bsr_we_i, .bsr_sel_i, .bsr_val_i, .mode_sel_i,
    .inte_o
  );

  sip_hs #(.DATA_W(DATA_W)) i_hs (
    .clk_i, .rst_ni,
    .stb_s_i(stb_s), .rd_s_i(rd_s), .pins_s_i(pins_s), .inte_i(inte_o),
    .data_o, .ibf_o, .intr_o, .rd_prev_o(rd_prev)
  );
endmodule

// File: rtl/strobe_in_port_chk.sv
module strobe_in_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stb_s,
  input logic              rd_s,
  input logic              rd_prev,
  input logic              mode_sel_i,
  input logic [DATA_W-1:0] data_o,
  input logic              ibf_o,
  input logic              intr_o,
  input logic              inte_o
);
  // R2
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_s |=> $stable(data_o));
  // R3
  ibf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_s |=> ibf_o);
  // R4
  ibf_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ibf_o) |-> $past(rd_s && !rd_prev));
  // R5
  intr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_s && ibf_o && inte_o && rd_s && rd_prev) |=> intr_o);
  // R6
  intr_rd_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_prev && !rd_s) |=> !intr_o);
  // R8
  mode_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_sel_i |=> !inte_o);
  // R10
  intr_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inte_o |=> !intr_o);
endmodule

bind strobe_in_port strobe_in_port_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i, .rst_ni, .stb_s, .rd_s, .rd_prev, .mode_sel_i,
  .data_o, .ibf_o, .intr_o, .inte_o
);

// File: tb/test_strobe_in_port.sv
module test_strobe_in_port;
  localparam int DATA_W   = 8;
  localparam int INTE_POS = 4;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [DATA_W-1:0] pins_i = '0;
  logic              stb_ni = 1'b1, rd_ni = 1'b1;
  logic              bsr_we_i = 1'b0, bsr_val_i = 1'b0, mode_sel_i = 1'b0;
  logic [2:0]        bsr_sel_i = '0;
  logic [DATA_W-1:0] data_o;
  logic              ibf_o, intr_o, inte_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // reference state
  logic [DATA_W-1:0] m_data = '0;
  logic              m_ibf = 1'b0, m_inte = 1'b0;

  always #2.5ns clk = ~clk;

  strobe_in_port i_strobe_in_port (
    .clk_i(clk), .rst_ni, .pins_i, .stb_ni, .rd_ni, .bsr_we_i, .bsr_sel_i,
    .bsr_val_i, .mode_sel_i, .data_o, .ibf_o, .intr_o, .inte_o
  );

  function automatic logic exp_intr(logic ibf, logic inte);
    return ibf & inte;
  endfunction

  function automatic logic exp_inte(logic cur, logic [2:0] sel, logic val);
    return (sel == 3'(INTE_POS)) ? val : cur;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_state(string req);
    check({req, " data"}, 32'(data_o), 32'(m_data));
    check({req, " ibf"},  32'(ibf_o),  32'(m_ibf));
    check({req, " inte"}, 32'(inte_o), 32'(m_inte));
    check({req, " intr"}, 32'(intr_o), 32'(exp_intr(m_ibf, m_inte)));
  endtask

  task automatic do_strobe(logic [DATA_W-1:0] d, int w);
    pins_i = d;
    stb_ni = 1'b0;
    cyc(w);
    stb_ni = 1'b1;
    cyc(3);
    m_data = d;
    m_ibf  = 1'b1;
    cyc(3);
  endtask

  task automatic do_read();
    rd_ni = 1'b0;
    cyc(5);
    check("R6 intr low during read", 32'(intr_o), 32'd0);
    check("R4 ibf held during read", 32'(ibf_o), 32'(m_ibf));
    rd_ni = 1'b1;
    cyc(5);
    m_ibf = 1'b0;
    check_state("R4 after read");
  endtask

  task automatic do_bsr(logic [2:0] sel, logic val);
    bsr_we_i = 1'b1; bsr_sel_i = sel; bsr_val_i = val;
    cyc(1);
    bsr_we_i = 1'b0;
    m_inte = exp_inte(m_inte, sel, val);
    cyc(3);
  endtask

  task automatic do_mode(logic with_bsr);
    mode_sel_i = 1'b1;
    bsr_we_i = with_bsr; bsr_sel_i = 3'(INTE_POS); bsr_val_i = 1'b1;
    cyc(1);
    mode_sel_i = 1'b0; bsr_we_i = 1'b0;
    m_inte = 1'b0;
    cyc(3);
  endtask

  initial begin
    void'($urandom(32'h5a17));
    cyc(2);
    check_state("R1 reset");
    rst_ni = 1'b1;
    cyc(2);
    check_state("R1 after release");

    // strobe with interrupts disabled: R2 R3 R10
    do_strobe(8'hA5, 1);
    check_state("R2 R3 R10 strobe masked");
    check("R3 ibf set", 32'(ibf_o), 32'd1);

    // latency of ibf: third edge after strobe low (R3)
    do_read();
    pins_i = 8'h3C;
    stb_ni = 1'b0;
    cyc(2);
    check("R3 ibf not before third edge", 32'(ibf_o), 32'd0);
    cyc(1);
    check("R3 ibf at third edge", 32'(ibf_o), 32'd1);
    check("R2 data latched", 32'(data_o), 32'h3C);
    stb_ni = 1'b1;
    cyc(4);
    m_data = 8'h3C; m_ibf = 1'b1;

    // enabling with full buffer raises intr (R7, R5)
    do_bsr(3'd4, 1'b1);
    check_state("R7 R5 enable with full buffer");
    check("R5 intr high", 32'(intr_o), 32'd1);
    do_read();

    // foreign bit positions ignored (R7)
    for (int b = 0; b < 8; b++) begin
      if (b != INTE_POS) begin
        do_bsr(3'(b), 1'b0);
        check("R7 other bit ignored", 32'(inte_o), 32'd1);
      end
    end

    // overwrite without read (R9)
    do_strobe(8'h11, 2);
    do_strobe(8'hE7, 3);
    check_state("R9 overwrite");
    check("R9 last byte", 32'(data_o), 32'hE7);

    // mode select beats same-cycle set (R8), intr drops (R10)
    do_mode(1'b1);
    check_state("R8 R10 mode select");
    check("R10 intr masked", 32'(intr_o), 32'd0);
    do_bsr(3'd4, 1'b1);
    check_state("R5 re-enable");
    do_read();

    // random mix
    for (int i = 0; i < 150; i++) begin
      int op;
      op = int'($urandom_range(0, 4));
      case (op)
        0: do_strobe(DATA_W'($urandom), int'($urandom_range(1, 3)));
        1: do_read();
        2: do_bsr(3'($urandom), 1'($urandom));
        3: do_mode(1'($urandom));
        default: cyc(int'($urandom_range(1, 4)));
      endcase
      check_state("R2 R4 R5 R7 R8 R10 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5ns);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule